// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master Bridge

This block lets slow internal logic run read and write cycles on an external peripheral that sits on a multiplexed Intel-style bus. That bus has one shared 8-bit address/data path, an address latch enable, and active-low chip select, read and write strobes. The requester places an address, a direction flag and write data on the internal side and raises a start strobe for one internal clock cycle. The bridge then runs the whole bus cycle by itself. It raises `busy` while the cycle is in progress. When the cycle ends it returns a one-cycle `done` pulse, and for a read it presents the captured byte with that pulse.

The bridge also makes the internal clock. It divides the fast bus-side clock by `DIV`, which is 4 by default, for example 20 MHz down to 5 MHz. All logic sits in the fast domain. The internal-side inputs are sampled only on the fast edge at which `slow_clk` rises, and the internal-side outputs change only on that edge. A register clocked by `slow_clk` therefore always sees stable values in both directions. The bidirectional pad is kept outside the block, which exposes the bus as a separate output, output enable and input.

Top module: `mux_bus_bridge`

## Requirements
- R1: `slow_clk` is high during reset. After reset it rises every `DIV` fast cycles and is high for the first `DIV/2` fast cycles of each period.
- R2: During reset and while idle: `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1; `bus_ale`, `bus_ad_oe`, `busy` and `done` are 0.
- R3: On a fast edge where `slow_clk` rises, `start`=1 with `busy`=0 is accepted. `busy` is 1 from that edge until the edge where `done` rises.
- R4: A `start` seen while `busy`=1 is ignored: no further bus cycle occurs and no peripheral location changes.
- R5: A bus cycle begins with `bus_cs_n`=0 and `bus_ale`=1 for `ADDR_CYC` fast cycles, with the address on `bus_ad_out` and `bus_ad_oe`=1. `bus_ale` then falls, and `bus_ad_out` keeps the address for `HOLD_CYC` cycles.
- R6: For a write (`wr_en`=1), `bus_wr_n` is 0 for `STRB_CYC` fast cycles, with `bus_ad_oe`=1 and `bus_ad_out` equal to the write data.
- R7: For a read (`wr_en`=0), `bus_rd_n` is 0 for `STRB_CYC` fast cycles with `bus_ad_oe`=0. `bus_ad_in` is sampled on the last fast edge at which `bus_rd_n` is still 0.
- R8: After the strobe, `bus_cs_n` stays 0 for `RECV_CYC` fast cycles with both strobes high, and then returns to 1. ALE and the strobes are only active while `bus_cs_n`=0.
- R9: `done` rises on the k-th `slow_clk` rising edge after acceptance, where k = ceil((ADDR_CYC+HOLD_CYC+STRB_CYC+RECV_CYC)/DIV). It is high for exactly one slow cycle. On a read, `rdata` holds the sampled byte from then until the next read completes.
- R10: `bus_ad_oe` is never 1 while `bus_rd_n`=0 or `bus_cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | bus-side clock |
| rst_n | input | 1 | asynchronous reset, active low |
| slow_clk | output | 1 | divided internal clock |
| start | input | 1 | begin a transaction (one slow cycle) |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | BUS_W | target address |
| wdata | input | BUS_W | write data |
| busy | output | 1 | transaction in progress |
| done | output | 1 | one-slow-cycle completion pulse |
| rdata | output | BUS_W | last read data |
| bus_cs_n | output | 1 | chip select, active low |
| bus_ale | output | 1 | address latch enable |
| bus_rd_n | output | 1 | read strobe, active low |
| bus_wr_n | output | 1 | write strobe, active low |
| bus_ad_out | output | BUS_W | value driven onto the shared bus |
| bus_ad_oe | output | 1 | output enable for the shared bus |
| bus_ad_in | input | BUS_W | value read from the shared bus |

## Verification
The bench keeps `DIV`=4, `ADDR_CYC`=2, `HOLD_CYC`=1 and `RECV_CYC`=1, but raises `STRB_CYC` to 5. The bus cycle then takes 9 fast cycles. It ends one fast cycle after a slow edge, so `done` is three slow edges after acceptance rather than two. This exercises the path where completion must wait for the next slow edge rather than landing on one.

// File: rtl/mib_pkg.sv
package mib_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_STRB,
    PH_RECV
  } phase_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int bus_cycle_len(input int a, input int h, input int s, input int r);
    return a + h + s + r;
  endfunction

  function automatic int slow_edges_to_done(input int total, input int div);
    return (total + div - 1) / div;
  endfunction

endpackage

// File: rtl/mib_clk_div.sv
module mib_clk_div #(
  parameter int DIV = 4
) (
  input  logic fast_clk,
  input  logic rst_n,
  output logic slow_clk,
  output logic slow_rise
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          slow_q;

  assign cnt_nxt   = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
  assign slow_rise = (cnt_q == CW'(DIV - 1));
  assign slow_clk  = slow_q;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slow_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      slow_q <= (cnt_nxt < CW'(HALF));
    end
  end
endmodule

// File: rtl/mib_bus_seq.sv
module mib_bus_seq
  import mib_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int ADDR_CYC = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 4,
  parameter int RECV_CYC = 1
) (
  input  logic             fast_clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_we,
  input  logic [BUS_W-1:0] go_addr,
  input  logic [BUS_W-1:0] go_wdata,
  input  logic [BUS_W-1:0] ad_in,
  output logic             cs_n,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             fin,
  output logic [BUS_W-1:0] cap_data
);
  localparam int MAXC = max_of4(ADDR_CYC, HOLD_CYC, STRB_CYC, RECV_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  phase_t           ph_q, ph_nxt;
  logic [CW-1:0]    cnt_q;
  logic             we_q;
  logic [BUS_W-1:0] addr_q, wdata_q, cap_q;
  logic             ph_last;

  function automatic logic [CW-1:0] phase_len(input phase_t p);
    case (p)
      PH_ADDR: return CW'(ADDR_CYC);
      PH_HOLD: return CW'(HOLD_CYC);
      PH_STRB: return CW'(STRB_CYC);
      PH_RECV: return CW'(RECV_CYC);
      default: return CW'(1);
    endcase
  endfunction

  assign ph_last = (cnt_q == phase_len(ph_q) - 1'b1);

  always_comb begin
    ph_nxt = ph_q;
    case (ph_q)
      PH_IDLE: if (go) ph_nxt = PH_ADDR;
      PH_ADDR: if (ph_last) ph_nxt = (HOLD_CYC > 0) ? PH_HOLD : PH_STRB;
      PH_HOLD: if (ph_last) ph_nxt = PH_STRB;
      PH_STRB: if (ph_last) ph_nxt = (RECV_CYC > 0) ? PH_RECV : PH_IDLE;
      PH_RECV: if (ph_last) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cap_q   <= '0;
    end else begin
      ph_q <= ph_nxt;
      if (ph_nxt != ph_q) cnt_q <= '0;
      else if (ph_q != PH_IDLE) cnt_q <= cnt_q + 1'b1;
      if (ph_q == PH_IDLE && go) begin
        we_q    <= go_we;
        addr_q  <= go_addr;
        wdata_q <= go_wdata;
      end
      if (ph_q == PH_STRB && ph_last && !we_q) cap_q <= ad_in;
    end
  end

  assign cs_n     = (ph_q == PH_IDLE);
  assign ale      = (ph_q == PH_ADDR);
  assign rd_n     = !(ph_q == PH_STRB && !we_q);
  assign wr_n     = !(ph_q == PH_STRB && we_q);
  assign ad_oe    = (ph_q == PH_ADDR) || (ph_q == PH_HOLD) || (ph_q == PH_STRB && we_q);
  assign ad_out   = (ph_q == PH_STRB && we_q) ? wdata_q : addr_q;
  assign fin      = ph_last && ((ph_q == PH_RECV) || (ph_q == PH_STRB && RECV_CYC == 0));
  assign cap_data = cap_q;
endmodule

// File: rtl/mib_req_port.sv
module mib_req_port #(
  parameter int BUS_W = 8
) (
  input  logic             fast_clk,
  input  logic             rst_n,
  input  logic             slow_rise,
  input  logic             start,
  input  logic             wr_en,
  input  logic             fin,
  input  logic [BUS_W-1:0] cap_data,
  output logic             go,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rdata
);
  logic             busy_q, done_q, pend_q, txn_we_q;
  logic [BUS_W-1:0] rdata_q;
  logic             finish_now;

  assign go         = slow_rise && start && !busy_q;
  assign finish_now = slow_rise && (pend_q || fin);

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      txn_we_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (fin && !slow_rise) pend_q <= 1'b1;
      else if (slow_rise)    pend_q <= 1'b0;
      if (slow_rise) begin
        done_q <= finish_now;
        if (finish_now) begin
          busy_q <= 1'b0;
          if (!txn_we_q) rdata_q <= cap_data;
        end else if (go) begin
          busy_q   <= 1'b1;
          txn_we_q <= wr_en;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
  parameter int BUS_W    = 8,
  parameter int DIV      = 4,
  parameter int ADDR_CYC = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 4,
  parameter int RECV_CYC = 1
) (
  input  logic             fast_clk,
  input  logic             rst_n,
  output logic             slow_clk,
  input  logic             start,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] rdata,
  output logic             bus_cs_n,
  output logic             bus_ale,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic [BUS_W-1:0] bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [BUS_W-1:0] bus_ad_in
);
  logic             slow_rise;
  logic             seq_go;
  logic             seq_fin;
  logic [BUS_W-1:0] seq_cap;

  mib_clk_div #(.DIV(DIV)) u_div (
    .fast_clk (fast_clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .slow_rise(slow_rise)
  );

  mib_req_port #(.BUS_W(BUS_W)) u_port (
    .fast_clk (fast_clk),
    .rst_n    (rst_n),
    .slow_rise(slow_rise),
    .start    (start),
    .wr_en    (wr_en),
    .fin      (seq_fin),
    .cap_data (seq_cap),
    .go       (seq_go),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

  mib_bus_seq #(
    .BUS_W   (BUS_W),
    .ADDR_CYC(ADDR_CYC),
    .HOLD_CYC(HOLD_CYC),
    .STRB_CYC(STRB_CYC),
    .RECV_CYC(RECV_CYC)
  ) u_seq (
    .fast_clk(fast_clk),
    .rst_n   (rst_n),
    .go      (seq_go),
    .go_we   (wr_en),
    .go_addr (addr),
    .go_wdata(wdata),
    .ad_in   (bus_ad_in),
    .cs_n    (bus_cs_n),
    .ale     (bus_ale),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .ad_out  (bus_ad_out),
    .ad_oe   (bus_ad_oe),
    .fin     (seq_fin),
    .cap_data(seq_cap)
  );
endmodule

// File: rtl/mib_checker.sv
module mib_checker #(
  parameter int BUS_W = 8
) (
  input logic             fast_clk,
  input logic             rst_n,
  input logic             slow_clk,
  input logic             slow_rise,
  input logic             seq_fin,
  input logic             busy,
  input logic             done,
  input logic             bus_cs_n,
  input logic             bus_ale,
  input logic             bus_rd_n,
  input logic             bus_wr_n,
  input logic             bus_ad_oe,
  input logic [BUS_W-1:0] bus_ad_out
);
  assert_slow_rise_R1: assert property (@(posedge fast_clk) disable iff (!rst_n)
    slow_rise |=> $rose(slow_clk));

  assert_oe_read_R10: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  assert_oe_idle_R10: assert property (@(posedge fast_clk) disable iff (!rst_n)
    bus_cs_n |-> !bus_ad_oe);

  assert_strobes_in_cs_R8: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (bus_ale || !bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  assert_strobe_excl_R6: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  assert_addr_held_R5: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (bus_ad_out == $past(bus_ad_out)));

  assert_ale_busy_R3: assert property (@(posedge fast_clk) disable iff (!rst_n)
    $rose(bus_ale) |-> busy);

  assert_done_not_busy_R9: assert property (@(posedge fast_clk) disable iff (!rst_n)
    done |-> !busy);

  assert_outputs_on_slow_edge_R9: assert property (@(posedge fast_clk) disable iff (!rst_n)
    !slow_rise |=> ($stable(done) && $stable(busy)));

  assert_fin_in_txn_R3: assert property (@(posedge fast_clk) disable iff (!rst_n)
    seq_fin |-> busy);
endmodule

bind mux_bus_bridge mib_checker #(.BUS_W(BUS_W)) u_chk (
  .fast_clk  (fast_clk),
  .rst_n     (rst_n),
  .slow_clk  (slow_clk),
  .slow_rise (slow_rise),
  .seq_fin   (seq_fin),
  .busy      (busy),
  .done      (done),
  .bus_cs_n  (bus_cs_n),
  .bus_ale   (bus_ale),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_ad_oe (bus_ad_oe),
  .bus_ad_out(bus_ad_out)
);

// File: tb/sim_mux_bus_bridge.sv
`timescale 1ns/1ps
module sim_mux_bus_bridge;
  localparam int BW = 8;
  localparam int DV = 4;
  localparam int AC = 2;
  localparam int HC = 1;
  localparam int SC = 5;
  localparam int RC = 1;

  logic          fast_clk = 1'b0;
  logic          rst_n    = 1'b0;
  logic          start    = 1'b0;
  logic          wr_en    = 1'b0;
  logic [BW-1:0] addr     = '0;
  logic [BW-1:0] wdata    = '0;
  logic          slow_clk, busy, done;
  logic [BW-1:0] rdata;
  logic          bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [BW-1:0] bus_ad_out, bus_ad_in;

  int total = 0;
  int bad   = 0;
  int txn_seen = 0;
  int ale_run = 0, strb_run = 0, rec_run = 0;
  bit after_strb = 0;
  bit strb_was_wr = 0;

  logic [BW-1:0] pmem [256];
  logic [BW-1:0] rmem [256];
  logic [BW-1:0] addr_lat = '0;

  always #2.5 fast_clk = ~fast_clk;

  mux_bus_bridge #(
    .BUS_W(BW), .DIV(DV), .ADDR_CYC(AC), .HOLD_CYC(HC), .STRB_CYC(SC), .RECV_CYC(RC)
  ) u0 (
    .fast_clk(fast_clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .start(start), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
  );

  function automatic int exp_done_edges();
    int len;
    len = AC + HC + SC + RC;
    return (len / DV) + ((len % DV) != 0 ? 1 : 0);
  endfunction

  function automatic logic [BW-1:0] init_val(input int a);
    return BW'((a * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // peripheral model
  assign bus_ad_in = (!bus_rd_n && !bus_cs_n) ? pmem[addr_lat] : 8'h5A;

  always @(negedge fast_clk) begin
    if (rst_n) begin
      if (bus_ale) addr_lat = bus_ad_out;
      if (!bus_wr_n && !bus_cs_n && bus_ad_oe) pmem[addr_lat] = bus_ad_out;
      // R5: ALE width
      if (bus_ale) ale_run++;
      else if (ale_run > 0) begin
        chk(ale_run == AC, "R5 ale width", ale_run, AC);
        ale_run = 0;
        txn_seen++;
      end
      // R10: no drive during read strobe
      if (!bus_rd_n) chk(!bus_ad_oe, "R10 oe in read", bus_ad_oe, 0);
      // R6/R7: strobe width
      if (!bus_rd_n || !bus_wr_n) begin
        strb_run++;
        strb_was_wr = !bus_wr_n;
      end else if (strb_run > 0) begin
        chk(strb_run == SC, strb_was_wr ? "R6 wr strobe width" : "R7 rd strobe width", strb_run, SC);
        strb_run = 0;
        after_strb = 1;
        rec_run = 0;
      end
      // R8: recovery length
      if (after_strb) begin
        if (!bus_cs_n && bus_rd_n && bus_wr_n) rec_run++;
        else if (bus_cs_n) begin
          chk(rec_run == RC, "R8 recovery", rec_run, RC);
          after_strb = 0;
        end
      end
    end
  end

  task automatic do_txn(input bit we, input logic [BW-1:0] a, input logic [BW-1:0] d,
                        input bit poke);
    int n;
    int seen0;
    logic [BW-1:0] pa;
    seen0 = txn_seen;
    pa = a ^ 8'h3C;
    @(negedge slow_clk);
    start = 1'b1; wr_en = we; addr = a; wdata = d;
    @(negedge slow_clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after accept", busy, 1);
    if (poke) begin
      start = 1'b1; wr_en = 1'b1; addr = pa; wdata = ~rmem[pa];
    end
    n = 0;
    while (!done && n < 20) begin
      @(negedge slow_clk);
      start = 1'b0;
      n++;
    end
    chk(n == exp_done_edges(), "R9 done latency", n, exp_done_edges());
    chk(busy == 1'b0, "R3 busy clear with done", busy, 0);
    if (we) begin
      rmem[a] = d;
      chk(pmem[a] == d, "R6 write data", pmem[a], d);
    end else begin
      chk(rdata == rmem[a], "R7 read data", rdata, rmem[a]);
    end
    @(negedge slow_clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    if (!we) chk(rdata == rmem[a], "R9 rdata held", rdata, rmem[a]);
    chk(txn_seen == seen0 + 1, "R4 one bus cycle per start", txn_seen - seen0, 1);
    if (poke) chk(pmem[pa] == rmem[pa], "R4 ignored start no write", pmem[pa], rmem[pa]);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    time t0, t1, t2;
    int unsigned seed;
    for (int i = 0; i < 256; i++) begin
      pmem[i] = init_val(i);
      rmem[i] = init_val(i);
    end
    seed = $urandom(32'd20250611);
    #1;
    repeat (3) @(negedge fast_clk);
    // R2 / R1 reset state
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R2 strobes idle", {bus_cs_n, bus_rd_n, bus_wr_n}, 7);
    chk(!bus_ale && !bus_ad_oe, "R2 ale/oe low", {bus_ale, bus_ad_oe}, 0);
    chk(!busy && !done, "R2 busy/done low", {busy, done}, 0);
    chk(slow_clk == 1'b1, "R1 slow clock high in reset", slow_clk, 1);
    rst_n = 1'b1;
    // R1 period and duty
    @(posedge slow_clk); t0 = $time;
    @(negedge slow_clk); t1 = $time;
    @(posedge slow_clk); t2 = $time;
    chk(int'(t2 - t0) == DV * 5, "R1 slow period", int'(t2 - t0), DV * 5);
    chk(int'(t1 - t0) == (DV / 2) * 5, "R1 slow high time", int'(t1 - t0), (DV / 2) * 5);
    @(negedge fast_clk);
    chk(bus_cs_n && !bus_ad_oe, "R2 idle after reset", {bus_cs_n, bus_ad_oe}, 2);
    // directed corners
    do_txn(1'b0, 8'h00, 8'h00, 1'b0);
    do_txn(1'b1, 8'hFF, 8'h00, 1'b0);
    do_txn(1'b0, 8'hFF, 8'h00, 1'b0);
    do_txn(1'b1, 8'h00, 8'hFF, 1'b0);
    do_txn(1'b0, 8'h00, 8'h00, 1'b0);
    do_txn(1'b1, 8'h55, 8'hAA, 1'b1);
    do_txn(1'b0, 8'h55, 8'h00, 1'b1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [BW-1:0] ra, rd;
      bit rw, rp;
      ra = BW'($urandom);
      rd = BW'($urandom);
      rw = 1'($urandom);
      rp = ($urandom % 5) == 0;
      do_txn(rw, ra, rd, rp);
    end
    repeat (4) @(negedge fast_clk);
    chk(bus_cs_n && !busy, "R2 idle at end", {bus_cs_n, busy}, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule